// File: doc/BRIEF.md
# Load Ordering Violation Detector

This block sits beside a load queue in an out-of-order core and watches store executions on behalf of every load in flight. Each load slot holds the load's sequence number, its address, whether it has already executed, and any store value it has picked up late. When a store executes, it presents its sequence number, address and data to all slots at once. A slot only reacts if the store is older than its load and the addresses are equal. If that load has not yet run, it keeps the store's value for later use. If it has already run, the load read stale memory and a violation is raised.

When one or more slots raise a violation in the same cycle, the block reports a single flush request. The request carries the sequence number of the oldest violating load. At that same clock edge the block drops every tracked load that is as young as that load or younger. When a load executes, the block returns, one cycle later, whether a late-forwarded value is held for it, along with the value and the sequence number of the store that supplied it. Refetch and re-execution are left to the surrounding pipeline.

Top module: `ld_order_guard`

## Requirements
- R1: While reset is high, and in the first cycle after it, `flush_valid` and `res_valid` are 0, and every slot is empty. Executing an empty slot gives `res_valid` = 0.
- R2: Sequence age is modular: a is older than b exactly when bit SEQ_W-1 of (a - b) mod 2^SEQ_W is 1. A store broadcast is ignored by a load when the store is not older than the load, or when the addresses differ.
- R3: Take a valid load that has not executed, and a broadcast from an older store to the same address. The slot keeps the store data and the store sequence number. A later execute of that slot gives, one cycle after the execute, `res_valid`=1, `res_hit`=1, `res_data` = the kept data and `res_seq` = the store's sequence number.
- R4: A slot that already holds a forwarded value ignores a broadcast from a store older than its current source. A matching broadcast from a store that is younger than the current source but still older than the load replaces the value.
- R5: An executed valid load, hit by a matching broadcast from an older store, raises `flush_valid` in the next cycle, with `flush_seq` set to that load's sequence number.
- R6: An executed load raises no violation when the value it used came from a store younger than the broadcasting store.
- R7: When several loads violate on one broadcast, `flush_seq` is the sequence number of the oldest of them.
- R8: At the clock edge that registers a flush, every valid slot whose sequence number is not older than `flush_seq` is emptied. Older slots keep their state.
- R9: A load whose execute arrives in the same cycle as a matching older-store broadcast counts as executed. It raises a violation instead of capturing the value, and its result reports the state it had before that broadcast.
- R10: Age comparison works across sequence-number wrap, provided the live span stays under half the sequence range.
- R11: Within one slot, free has priority over allocate, and allocate has priority over flush removal. A load allocated in the same cycle as a broadcast is not compared against that broadcast. A freed slot reports `res_valid` = 0 on execute.
- R12: Without a violating broadcast, `flush_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Enter a load into a slot |
| alloc_slot | input | SLOT_W | Slot being filled |
| alloc_seq | input | SEQ_W | Load sequence number |
| alloc_addr | input | ADDR_W | Load address |
| exec_valid | input | 1 | Load in a slot executes now |
| exec_slot | input | SLOT_W | Executing slot |
| free_valid | input | 1 | Release a slot |
| free_slot | input | SLOT_W | Slot released |
| st_valid | input | 1 | Store broadcast this cycle |
| st_seq | input | SEQ_W | Store sequence number |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| res_valid | output | 1 | Execute result for a valid slot |
| res_hit | output | 1 | Slot held a late-forwarded value |
| res_seq | output | SEQ_W | Sequence number of the source store |
| res_data | output | DATA_W | Forwarded data |
| flush_valid | output | 1 | Flush request |
| flush_seq | output | SEQ_W | Oldest violating load; flush from here |

## Verification
A load's own execute and a store broadcast to the same address can land in the same cycle. This decides whether the slot captures the value or reports a violation. The bench provokes this directly, by pairing an execute with a matching older-store broadcast, and also lets random traffic pair them freely. A reference model in the bench treats the executing load as already run. From that model the bench predicts the flush sequence number and the pre-broadcast result, and compares both with the outputs one cycle later.

// File: rtl/log_pkg.sv
`timescale 1ns/1ps
package log_pkg;
  localparam int unsigned SEQ_MAXW = 32;

  // a older than b: modular difference, sign bit moved to the top
  function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b,
                                     input int unsigned w);
    logic [31:0] d;
    d = (a - b) << (SEQ_MAXW - w);
    return d[SEQ_MAXW-1];
  endfunction
endpackage

// File: rtl/log_entry.sv
`timescale 1ns/1ps
module log_entry #(
  parameter int SEQ_W  = 10,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              free_en,
  input  logic              alloc_en,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              exec_en,
  input  logic              kill_en,
  input  logic [SEQ_W-1:0]  kill_seq,
  input  logic              st_valid,
  input  logic [SEQ_W-1:0]  st_seq,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              e_valid,
  output logic [SEQ_W-1:0]  e_seq,
  output logic              e_fwd_valid,
  output logic [SEQ_W-1:0]  e_fwd_seq,
  output logic [DATA_W-1:0] e_fwd_data,
  output logic              e_viol
);
  import log_pkg::*;

  logic              valid_q, ran_q, fwd_q;
  logic [SEQ_W-1:0]  seq_q, fseq_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] fdata_q;

  logic match, ran_now, shadowed, take, dropped;

  always_comb begin
    match    = valid_q && st_valid && (addr_q == st_addr)
               && seq_older(32'(st_seq), 32'(seq_q), SEQ_W);
    ran_now  = ran_q || exec_en;
    shadowed = fwd_q && seq_older(32'(st_seq), 32'(fseq_q), SEQ_W);
    e_viol   = match && ran_now && !shadowed;
    take     = match && !ran_now
               && (!fwd_q || seq_older(32'(fseq_q), 32'(st_seq), SEQ_W));
    dropped  = valid_q && kill_en && !seq_older(32'(seq_q), 32'(kill_seq), SEQ_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      ran_q   <= 1'b0;
      fwd_q   <= 1'b0;
    end else if (free_en) begin
      valid_q <= 1'b0;
    end else if (alloc_en) begin
      valid_q <= 1'b1;
      ran_q   <= 1'b0;
      fwd_q   <= 1'b0;
    end else if (dropped) begin
      valid_q <= 1'b0;
    end else begin
      if (take)               fwd_q <= 1'b1;
      if (exec_en && valid_q) ran_q <= 1'b1;
    end
  end

  // payload fields carry no reset
  always_ff @(posedge clk) begin
    if (!free_en && alloc_en) begin
      seq_q  <= alloc_seq;
      addr_q <= alloc_addr;
    end
    if (!free_en && !alloc_en && !dropped && take) begin
      fseq_q  <= st_seq;
      fdata_q <= st_data;
    end
  end

  assign e_valid     = valid_q;
  assign e_seq       = seq_q;
  assign e_fwd_valid = fwd_q;
  assign e_fwd_seq   = fseq_q;
  assign e_fwd_data  = fdata_q;
endmodule

// File: rtl/log_oldest_pick.sv
`timescale 1ns/1ps
module log_oldest_pick #(
  parameter int N     = 16,
  parameter int SEQ_W = 10
) (
  input  logic [N-1:0]     cand,
  input  logic [SEQ_W-1:0] seqs [N],
  output logic             any,
  output logic [SEQ_W-1:0] oldest
);
  import log_pkg::*;

  always_comb begin
    any    = 1'b0;
    oldest = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!any || seq_older(32'(seqs[i]), 32'(oldest), SEQ_W))) begin
        any    = 1'b1;
        oldest = seqs[i];
      end
    end
  end
endmodule

// File: rtl/log_exec_port.sv
`timescale 1ns/1ps
module log_exec_port #(
  parameter int N      = 16,
  parameter int SLOT_W = 4,
  parameter int SEQ_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_valid,
  input  logic [SLOT_W-1:0] exec_slot,
  input  logic              ent_valid    [N],
  input  logic              ent_fwd      [N],
  input  logic [SEQ_W-1:0]  ent_fwd_seq  [N],
  input  logic [DATA_W-1:0] ent_fwd_data [N],
  output logic              res_valid,
  output logic              res_hit,
  output logic [SEQ_W-1:0]  res_seq,
  output logic [DATA_W-1:0] res_data
);
  logic              sel_v, sel_f;
  logic [SEQ_W-1:0]  sel_s;
  logic [DATA_W-1:0] sel_d;

  always_comb begin
    sel_v = 1'b0;
    sel_f = 1'b0;
    sel_s = '0;
    sel_d = '0;
    for (int i = 0; i < N; i++) begin
      if (exec_slot == SLOT_W'(i)) begin
        sel_v = ent_valid[i];
        sel_f = ent_fwd[i];
        sel_s = ent_fwd_seq[i];
        sel_d = ent_fwd_data[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_seq   <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= exec_valid && sel_v;
      res_hit   <= exec_valid && sel_v && sel_f;
      res_seq   <= sel_s;
      res_data  <= sel_d;
    end
  end
endmodule

// File: rtl/ld_order_guard.sv
`timescale 1ns/1ps
module ld_order_guard #(
  parameter int N_LOADS = 16,
  parameter int SEQ_W   = 10,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  localparam int SLOT_W = (N_LOADS > 1) ? $clog2(N_LOADS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [SLOT_W-1:0] alloc_slot,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              exec_valid,
  input  logic [SLOT_W-1:0] exec_slot,
  input  logic              free_valid,
  input  logic [SLOT_W-1:0] free_slot,
  input  logic              st_valid,
  input  logic [SEQ_W-1:0]  st_seq,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              res_valid,
  output logic              res_hit,
  output logic [SEQ_W-1:0]  res_seq,
  output logic [DATA_W-1:0] res_data,
  output logic              flush_valid,
  output logic [SEQ_W-1:0]  flush_seq
);
  logic              ent_valid    [N_LOADS];
  logic [SEQ_W-1:0]  ent_seq      [N_LOADS];
  logic              ent_fwd      [N_LOADS];
  logic [SEQ_W-1:0]  ent_fwd_seq  [N_LOADS];
  logic [DATA_W-1:0] ent_fwd_data [N_LOADS];
  logic [N_LOADS-1:0] viol_vec;

  logic             viol_any;
  logic [SEQ_W-1:0] viol_seq;

  for (genvar g = 0; g < N_LOADS; g++) begin : g_slot
    log_entry #(.SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ent (
      .clk         (clk),
      .rst         (rst),
      .free_en     (free_valid  && (free_slot  == SLOT_W'(g))),
      .alloc_en    (alloc_valid && (alloc_slot == SLOT_W'(g))),
      .alloc_seq   (alloc_seq),
      .alloc_addr  (alloc_addr),
      .exec_en     (exec_valid  && (exec_slot  == SLOT_W'(g))),
      .kill_en     (viol_any),
      .kill_seq    (viol_seq),
      .st_valid    (st_valid),
      .st_seq      (st_seq),
      .st_addr     (st_addr),
      .st_data     (st_data),
      .e_valid     (ent_valid[g]),
      .e_seq       (ent_seq[g]),
      .e_fwd_valid (ent_fwd[g]),
      .e_fwd_seq   (ent_fwd_seq[g]),
      .e_fwd_data  (ent_fwd_data[g]),
      .e_viol      (viol_vec[g])
    );
  end

  log_oldest_pick #(.N(N_LOADS), .SEQ_W(SEQ_W)) u_pick (
    .cand   (viol_vec),
    .seqs   (ent_seq),
    .any    (viol_any),
    .oldest (viol_seq)
  );

  log_exec_port #(.N(N_LOADS), .SLOT_W(SLOT_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W)) u_port (
    .clk          (clk),
    .rst          (rst),
    .exec_valid   (exec_valid),
    .exec_slot    (exec_slot),
    .ent_valid    (ent_valid),
    .ent_fwd      (ent_fwd),
    .ent_fwd_seq  (ent_fwd_seq),
    .ent_fwd_data (ent_fwd_data),
    .res_valid    (res_valid),
    .res_hit      (res_hit),
    .res_seq      (res_seq),
    .res_data     (res_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_valid <= 1'b0;
      flush_seq   <= '0;
    end else begin
      flush_valid <= viol_any;
      if (viol_any) flush_seq <= viol_seq;
    end
  end
endmodule

// File: rtl/ld_order_guard_chk.sv
`timescale 1ns/1ps
module ld_order_guard_chk #(
  parameter int SEQ_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             st_valid,
  input logic [SEQ_W-1:0] st_seq,
  input logic             exec_valid,
  input logic             res_valid,
  input logic             flush_valid,
  input logic [SEQ_W-1:0] flush_seq
);
  import log_pkg::*;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!flush_valid && !res_valid)); // R1

  AST_FLUSH_NEEDS_STORE: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> $past(st_valid)); // R12

  AST_FLUSH_AFTER_STORE: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> seq_older(32'($past(st_seq)), 32'(flush_seq), SEQ_W)); // R2

  AST_RES_NEEDS_EXEC: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(exec_valid)); // R3
endmodule

bind ld_order_guard ld_order_guard_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .st_valid    (st_valid),
  .st_seq      (st_seq),
  .exec_valid  (exec_valid),
  .res_valid   (res_valid),
  .flush_valid (flush_valid),
  .flush_seq   (flush_seq)
);

// File: tb/ld_order_guard_tb.sv
`timescale 1ns/1ps
module ld_order_guard_tb;
  localparam int N  = 8;
  localparam int SW = 8;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          alloc_valid = 0, exec_valid = 0, free_valid = 0, st_valid = 0;
  logic [LW-1:0] alloc_slot = '0, exec_slot = '0, free_slot = '0;
  logic [SW-1:0] alloc_seq = '0, st_seq = '0;
  logic [AW-1:0] alloc_addr = '0, st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          res_valid, res_hit, flush_valid;
  logic [SW-1:0] res_seq, flush_seq;
  logic [DW-1:0] res_data;

  ld_order_guard #(.N_LOADS(N), .SEQ_W(SW), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_slot(alloc_slot), .alloc_seq(alloc_seq), .alloc_addr(alloc_addr),
    .exec_valid(exec_valid), .exec_slot(exec_slot),
    .free_valid(free_valid), .free_slot(free_slot),
    .st_valid(st_valid), .st_seq(st_seq), .st_addr(st_addr), .st_data(st_data),
    .res_valid(res_valid), .res_hit(res_hit), .res_seq(res_seq), .res_data(res_data),
    .flush_valid(flush_valid), .flush_seq(flush_seq)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference state
  bit            m_v [N];
  bit            m_ex[N];
  bit            m_fv[N];
  logic [SW-1:0] m_seq[N];
  logic [SW-1:0] m_fs [N];
  logic [AW-1:0] m_a  [N];
  logic [DW-1:0] m_fd [N];
  logic [SW-1:0] gseq;

  function automatic bit older(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [SW-1:0] d;
    d = a - b;
    return d[SW-1];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic set_alloc(input int s, input int sq, input int ad);
    alloc_valid = 1; alloc_slot = LW'(s); alloc_seq = SW'(sq); alloc_addr = AW'(ad);
  endtask
  task automatic set_exec(input int s);
    exec_valid = 1; exec_slot = LW'(s);
  endtask
  task automatic set_free(input int s);
    free_valid = 1; free_slot = LW'(s);
  endtask
  task automatic set_st(input int sq, input int ad, input int dt);
    st_valid = 1; st_seq = SW'(sq); st_addr = AW'(ad); st_data = DW'(dt);
  endtask

  // one cycle: predict, clock, update model, compare at the falling edge
  task automatic step(input string tag);
    bit            e_rv, e_hit, any;
    logic [SW-1:0] e_src, vs;
    logic [DW-1:0] e_dat;
    bit            viol[N];
    bit            take[N];
    e_rv  = exec_valid && m_v[exec_slot];
    e_hit = m_fv[exec_slot];
    e_src = m_fs[exec_slot];
    e_dat = m_fd[exec_slot];
    any = 0; vs = '0;
    for (int i = 0; i < N; i++) begin
      bit hit, ran;
      hit = m_v[i] && st_valid && (m_a[i] == st_addr) && older(st_seq, m_seq[i]);
      ran = m_ex[i] || (exec_valid && exec_slot == LW'(i));
      viol[i] = hit && ran && !(m_fv[i] && older(st_seq, m_fs[i]));
      take[i] = hit && !ran && (!m_fv[i] || older(m_fs[i], st_seq));
      if (viol[i] && (!any || older(m_seq[i], vs))) begin
        any = 1; vs = m_seq[i];
      end
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (free_valid && free_slot == LW'(i)) m_v[i] = 0;
      else if (alloc_valid && alloc_slot == LW'(i)) begin
        m_v[i] = 1; m_ex[i] = 0; m_fv[i] = 0; m_seq[i] = alloc_seq; m_a[i] = alloc_addr;
      end else if (any && m_v[i] && !older(m_seq[i], vs)) m_v[i] = 0;
      else begin
        if (take[i]) begin m_fv[i] = 1; m_fs[i] = st_seq; m_fd[i] = st_data; end
        if (exec_valid && exec_slot == LW'(i) && m_v[i]) m_ex[i] = 1;
      end
    end
    @(negedge clk);
    check(res_valid == e_rv, tag, "res_valid", 32'(res_valid), 32'(e_rv));
    if (e_rv) begin
      check(res_hit == e_hit, tag, "res_hit", 32'(res_hit), 32'(e_hit));
      if (e_hit) begin
        check(res_data == e_dat, tag, "res_data", 32'(res_data), 32'(e_dat));
        check(res_seq == e_src, tag, "res_seq", 32'(res_seq), 32'(e_src));
      end
    end
    check(flush_valid == any, tag, "flush_valid", 32'(flush_valid), 32'(any));
    if (any) check(flush_seq == vs, tag, "flush_seq", 32'(flush_seq), 32'(vs));
    alloc_valid = 0; exec_valid = 0; free_valid = 0; st_valid = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_ex[i] = 0; m_fv[i] = 0; m_seq[i] = '0; m_fs[i] = '0; m_a[i] = '0; m_fd[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(flush_valid == 0, "R1", "flush_valid after reset", 32'(flush_valid), 0);
    check(res_valid == 0, "R1", "res_valid after reset", 32'(res_valid), 0);
    set_exec(0); step("R1");

    // R2: younger store and address mismatch ignored
    set_alloc(0, 100, 5); step("R2");
    set_st(102, 5, 'h111); step("R2");
    set_st(98, 6, 'h222); step("R2");
    set_exec(0); step("R2");
    // R3: late capture reported on execute
    set_alloc(1, 110, 3); step("R3");
    set_st(105, 3, 'hAAAA); step("R3");
    set_exec(1); step("R3");
    // R4: closest older store wins
    set_alloc(2, 130, 4); step("R4");
    set_st(125, 4, 'h1001); step("R4");
    set_st(120, 4, 'h1002); step("R4");
    set_st(127, 4, 'h1003); step("R4");
    set_exec(2); step("R4");
    // R5: executed load then older store
    set_alloc(3, 140, 7); step("R5");
    set_exec(3); step("R5");
    set_st(135, 7, 'h5); step("R5");
    // R6: shadowed by a younger forwarded source
    set_alloc(4, 150, 2); step("R6");
    set_st(148, 2, 'h66); step("R6");
    set_exec(4); step("R6");
    set_st(145, 2, 'h67); step("R6");
    set_st(149, 2, 'h68); step("R5");
    // R7, R8: two violators, oldest wins, younger slots removed
    set_alloc(0, 160, 1); step("R7");
    set_alloc(1, 162, 1); step("R7");
    set_alloc(2, 165, 9); step("R8");
    set_alloc(3, 158, 9); step("R8");
    set_exec(0); step("R7");
    set_exec(1); step("R7");
    set_st(155, 1, 'h77); step("R7");
    set_exec(2); step("R8");
    set_exec(3); step("R8");
    // R9: execute and matching broadcast together
    set_alloc(5, 170, 6); step("R9");
    set_st(166, 6, 'h90); step("R9");
    set_exec(5); set_st(168, 6, 'h91); step("R9");
    // R10: wrap of sequence numbers
    set_alloc(6, 2, 8); step("R10");
    set_st(250, 8, 'hA0); step("R10");
    set_st(5, 8, 'hA1); step("R10");
    set_exec(6); step("R10");
    // R11: alloc with same-cycle broadcast, then free
    set_alloc(7, 20, 3); set_st(15, 3, 'hB0); step("R11");
    set_exec(7); step("R11");
    set_free(7); step("R11");
    set_exec(7); step("R11");
    // R12: idle
    step("R12");
    for (int i = 0; i < N; i++) begin set_free(i); step("R11"); end

    // random traffic
    gseq = 8'd30;
    for (int c = 0; c < 3000; c++) begin
      int fs, as, es, off;
      fs = -1; as = -1; es = -1;
      for (int i = 0; i < N; i++)
        if (fs < 0 && m_v[i] && older(m_seq[i], gseq - 8'd40)) fs = i;
      if (fs < 0 && ($urandom % 8) == 0) begin
        off = int'($urandom % N);
        for (int k = 0; k < N; k++)
          if (fs < 0 && m_v[(k + off) % N]) fs = (k + off) % N;
      end
      if (fs >= 0) set_free(fs);
      if (($urandom % 2) == 0) begin
        off = int'($urandom % N);
        for (int k = 0; k < N; k++)
          if (as < 0 && !m_v[(k + off) % N] && (k + off) % N != fs) as = (k + off) % N;
        if (as >= 0) begin
          gseq = gseq + SW'(1 + ($urandom % 2));
          set_alloc(as, int'(gseq), int'($urandom % 4));
        end
      end
      if (($urandom % 2) == 0) begin
        off = int'($urandom % N);
        for (int k = 0; k < N; k++) begin
          int s;
          s = (k + off) % N;
          if (es < 0 && m_v[s] && !m_ex[s] && s != fs && s != as) es = s;
        end
        if (es >= 0) set_exec(es);
      end
      if (($urandom % 2) == 0)
        set_st(int'(gseq - 8'd20 + SW'($urandom % 26)), int'($urandom % 4), int'($urandom));
      step("R7");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule